// File: doc/BRIEF.md
# NAND Page-Read Boot Copy Engine

This block moves data from a large-page, byte-wide NAND flash device into on-chip memory with no processor involvement. Every transfer works in whole 2048-byte pages. Each page follows the same fixed sequence. First the device is reset and the engine waits for it to report ready. It then reopens the device and sends a read command, five address bytes and a read-confirm command. After the device reports ready again, the engine clocks out the whole page one byte at a time. Each byte is written to the next address of a byte-wide memory write port.

The engine runs in two modes. When synchronous reset is released, it fills the boot SRAM with the first `BOOT_BYTES` of the device, starting at flash address zero. Only after that does it raise the processor-release output. Once released, the engine takes copy requests: a flash start address, a byte length and a destination address. It copies enough pages to cover the length and pulses a done strobe at the end. Every ready/busy wait is limited by a timeout. If the device stays busy too long, the engine raises an error flag and goes back to idle.

Top module: `nand_boot_copier`

## Requirements
- R1: After reset is released, the engine copies `BOOT_BYTES` (default 4096) from flash page 0 onward to memory addresses 0 upward. During this boot copy `mem_to_sram` is 1; during requested copies it is 0.
- R2: `cpu_release` is 0 from reset until the boot copy has written its last byte. It then goes to 1 and stays there, and no SRAM write happens after it rises.
- R3: Before each page, chip enable goes low and command 0xFF is sent with CLE high. The engine then waits for ready and drives chip enable high for at least one cycle before the read sequence.
- R4: Each page read sends command 0x00 and then five ALE cycles carrying 0x00, 0x00, row[7:0], row[15:8], row[23:16]. It then sends command 0x30, and RE# is not pulsed until the device reports ready again. Row is the start page plus the number of pages already copied.
- R5: Every page delivers exactly 2048 bytes, read in column order. They are written to consecutive addresses starting at the destination, and chip enable is high after the last byte.
- R6: A request copies ceil(len/2048) whole pages, so a partial final page is still read in full. A length of 0 produces no flash activity.
- R7: Bits [10:0] of the flash start address have no effect; the copy starts at column 0 of page `addr >> 11`.
- R8: `req_done` is high for exactly one cycle at the end of each accepted request, and never for the boot copy.
- R9: `req_start` is ignored while the boot copy or a requested copy is in progress.
- R10: If ready is not seen within `RB_TIMEOUT` cycles of any wait, chip enable goes high, `copy_err` rises, `req_done` pulses and no further bytes are written. `copy_err` clears when the next request is accepted.
- R11: WE# and RE# are each low for exactly `T_PULSE` cycles and never both at once, and only while chip enable is low. CLE and ALE are never both high, and `nand_io_oe` is 0 while RE# is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven onto the flash bus |
| nand_io_oe | output | 1 | Bus drive enable for `nand_io_out` |
| nand_io_in | input | 8 | Byte returned by the flash |
| nand_rb | input | 1 | Ready/busy, 1 = ready (asynchronous) |
| mem_we | output | 1 | Memory byte write enable |
| mem_to_sram | output | 1 | 1 when the write targets the boot SRAM |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| req_start | input | 1 | Start a requested copy (sampled in idle) |
| req_flash_addr | input | ADDR_W | Flash byte start address |
| req_len | input | LEN_W | Byte count to copy |
| req_dest | input | MEM_AW | Destination start address |
| req_done | output | 1 | One-cycle end-of-request pulse |
| cpu_release | output | 1 | Processor may start running |
| copy_err | output | 1 | Ready/busy timeout seen |

## Verification
The properties assume that the flash model only returns data while RE# is low. They also assume ready/busy goes low for some bounded time after each reset or read-confirm command, or stays low long enough to hit the timeout. The bench model follows this contract exactly. It holds busy for a fixed number of cycles after 0xFF and 0x30, and it has a stuck-busy switch that is used only in the timeout case. Requests are sent only when the engine is idle, with one deliberate exception: extra start pulses are issued during the boot copy and during a long copy to show they are ignored. Random requests draw page numbers and lengths within the 24-bit row space and keep to one page each, so the run stays short.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

    typedef enum logic [1:0] {
        OP_CMD,
        OP_ADDR,
        OP_READ
    } nbc_op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD
    } nbc_phase_e;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_IDLE,
        ST_CHECK,
        ST_RST_GO,
        ST_RST_WAIT,
        ST_RD_CE,
        ST_RD1_GO,
        ST_ADDR_GO,
        ST_RD2_GO,
        ST_RD_WAIT,
        ST_DATA_GO,
        ST_DATA_PUT,
        ST_PAGE_END,
        ST_FINISH,
        ST_FAIL,
        ST_STRB
    } nbc_state_e;

    typedef struct packed {
        nbc_op_e    op;
        logic [7:0] data;
    } nbc_bus_req_t;

    localparam logic [7:0] NBC_OPC_RESET   = 8'hFF;
    localparam logic [7:0] NBC_OPC_READ    = 8'h00;
    localparam logic [7:0] NBC_OPC_CONFIRM = 8'h30;
    localparam int         NBC_ROW_W       = 24;
    localparam logic [2:0] NBC_LAST_ADDR   = 3'd4;

    // Address cycle byte: two zero column bytes, then row bytes LSB first.
    function automatic logic [7:0] nbc_addr_byte(input logic [2:0] idx,
                                                 input logic [NBC_ROW_W-1:0] row);
        logic [7:0] b;
        case (idx)
            3'd2:    b = row[7:0];
            3'd3:    b = row[15:8];
            3'd4:    b = row[23:16];
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/nbc_strobe.sv
module nbc_strobe
    import nbc_pkg::*;
#(
    parameter int T_SETUP = 1,
    parameter int T_PULSE = 1,
    parameter int T_HOLD  = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  nbc_bus_req_t req,
    input  logic [7:0]   io_in,
    output logic         we_n,
    output logic         re_n,
    output logic         cle,
    output logic         ale,
    output logic [7:0]   io_out,
    output logic         io_oe,
    output logic [7:0]   rdata,
    output logic         done
);
    localparam int CNT_W = $clog2(T_SETUP + T_PULSE + T_HOLD + 1) + 1;

    nbc_phase_e       phase;
    logic [CNT_W-1:0] cnt;
    logic             is_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            we_n    <= 1'b1;
            re_n    <= 1'b1;
            cle     <= 1'b0;
            ale     <= 1'b0;
            io_out  <= '0;
            io_oe   <= 1'b0;
            rdata   <= '0;
            done    <= 1'b0;
            is_read <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (go) begin
                        phase   <= PH_SETUP;
                        cnt     <= CNT_W'(T_SETUP - 1);
                        cle     <= (req.op == OP_CMD);
                        ale     <= (req.op == OP_ADDR);
                        io_oe   <= (req.op != OP_READ);
                        io_out  <= req.data;
                        is_read <= (req.op == OP_READ);
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_PULSE;
                        cnt   <= CNT_W'(T_PULSE - 1);
                        if (is_read) re_n <= 1'b0;
                        else         we_n <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_PULSE: begin
                    if (cnt == '0) begin
                        we_n <= 1'b1;
                        re_n <= 1'b1;
                        if (is_read) rdata <= io_in;
                        if (T_HOLD == 0) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                            cle   <= 1'b0;
                            ale   <= 1'b0;
                            io_oe <= 1'b0;
                        end else begin
                            phase <= PH_HOLD;
                            cnt   <= CNT_W'(T_HOLD - 1);
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                        cle   <= 1'b0;
                        ale   <= 1'b0;
                        io_oe <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/nbc_rb_wait.sv
module nbc_rb_wait #(
    parameter int MIN_WAIT = 4,
    parameter int TIMEOUT  = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic rb_async,
    input  logic clr,
    input  logic arm,
    output logic ready,
    output logic timeout
);
    localparam int TW = $clog2(TIMEOUT + MIN_WAIT + 1) + 1;
    localparam logic [TW-1:0] T_MAX  = TW'(TIMEOUT - 1);
    localparam logic [TW-1:0] T_MIN  = TW'(MIN_WAIT);

    logic          rb_q1, rb_q2;
    logic          busy_seen;
    logic [TW-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rb_q1     <= 1'b1;
            rb_q2     <= 1'b1;
            busy_seen <= 1'b0;
            tcnt      <= '0;
        end else begin
            rb_q1 <= rb_async;
            rb_q2 <= rb_q1;
            if (clr)         busy_seen <= 1'b0;
            else if (!rb_q2) busy_seen <= 1'b1;
            if (!arm)              tcnt <= '0;
            else if (tcnt < T_MAX) tcnt <= tcnt + 1'b1;
        end
    end

    assign ready   = arm && rb_q2 && (busy_seen || tcnt >= T_MIN);
    assign timeout = arm && !ready && (tcnt >= T_MAX);

endmodule

// File: rtl/nbc_seq.sv
module nbc_seq
    import nbc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 32,
    parameter int MEM_AW     = 32,
    parameter int PAGE_BYTES = 2048,
    parameter int BOOT_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_start,
    input  logic [ADDR_W-1:0] req_flash_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [MEM_AW-1:0] req_dest,
    output logic              s_go,
    output nbc_bus_req_t      s_req,
    input  logic              s_done,
    input  logic [7:0]        s_rdata,
    output logic              w_clr,
    output logic              w_arm,
    input  logic              w_ready,
    input  logic              w_timeout,
    output logic              ce_n,
    output logic              mem_we,
    output logic              mem_to_sram,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              req_done,
    output logic              cpu_release,
    output logic              copy_err
);
    localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
    localparam logic [PAGE_SHIFT-1:0] LAST_COL = PAGE_SHIFT'(PAGE_BYTES - 1);
    localparam logic signed [LEN_W:0] PAGE_DEC  = (LEN_W+1)'(PAGE_BYTES);
    localparam logic signed [LEN_W:0] BOOT_LEN  = (LEN_W+1)'(BOOT_BYTES);

    nbc_state_e               state, ret;
    logic                     boot_mode;
    logic [NBC_ROW_W-1:0]     page;
    logic signed [LEN_W:0]    remain;
    logic [MEM_AW-1:0]        dest;
    logic [PAGE_SHIFT-1:0]    col;
    logic [2:0]               addr_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_BOOT;
            ret         <= ST_IDLE;
            boot_mode   <= 1'b1;
            page        <= '0;
            remain      <= '0;
            dest        <= '0;
            col         <= '0;
            addr_idx    <= '0;
            ce_n        <= 1'b1;
            req_done    <= 1'b0;
            cpu_release <= 1'b0;
            copy_err    <= 1'b0;
        end else begin
            req_done <= 1'b0;
            case (state)
                ST_BOOT: begin
                    boot_mode <= 1'b1;
                    page      <= '0;
                    remain    <= BOOT_LEN;
                    dest      <= '0;
                    state     <= ST_CHECK;
                end
                ST_IDLE: begin
                    if (req_start) begin
                        boot_mode <= 1'b0;
                        page      <= NBC_ROW_W'(req_flash_addr >> PAGE_SHIFT);
                        remain    <= $signed({1'b0, req_len});
                        dest      <= req_dest;
                        copy_err  <= 1'b0;
                        state     <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (remain > 0) begin
                        ce_n  <= 1'b0;
                        state <= ST_RST_GO;
                    end else begin
                        state <= ST_FINISH;
                    end
                end
                ST_RST_GO: begin
                    ret   <= ST_RST_WAIT;
                    state <= ST_STRB;
                end
                ST_RST_WAIT: begin
                    if (w_ready) begin
                        ce_n  <= 1'b1;
                        state <= ST_RD_CE;
                    end else if (w_timeout) begin
                        state <= ST_FAIL;
                    end
                end
                ST_RD_CE: begin
                    ce_n  <= 1'b0;
                    state <= ST_RD1_GO;
                end
                ST_RD1_GO: begin
                    addr_idx <= '0;
                    ret      <= ST_ADDR_GO;
                    state    <= ST_STRB;
                end
                ST_ADDR_GO: begin
                    addr_idx <= addr_idx + 1'b1;
                    ret      <= (addr_idx == NBC_LAST_ADDR) ? ST_RD2_GO : ST_ADDR_GO;
                    state    <= ST_STRB;
                end
                ST_RD2_GO: begin
                    ret   <= ST_RD_WAIT;
                    state <= ST_STRB;
                end
                ST_RD_WAIT: begin
                    if (w_ready) begin
                        col   <= '0;
                        state <= ST_DATA_GO;
                    end else if (w_timeout) begin
                        state <= ST_FAIL;
                    end
                end
                ST_DATA_GO: begin
                    ret   <= ST_DATA_PUT;
                    state <= ST_STRB;
                end
                ST_DATA_PUT: begin
                    if (col == LAST_COL) begin
                        state <= ST_PAGE_END;
                    end else begin
                        col   <= col + 1'b1;
                        state <= ST_DATA_GO;
                    end
                end
                ST_PAGE_END: begin
                    ce_n   <= 1'b1;
                    remain <= remain - PAGE_DEC;
                    dest   <= dest + MEM_AW'(PAGE_BYTES);
                    page   <= page + 1'b1;
                    state  <= ST_CHECK;
                end
                ST_FINISH: begin
                    if (boot_mode) cpu_release <= 1'b1;
                    else           req_done    <= 1'b1;
                    boot_mode <= 1'b0;
                    state     <= ST_IDLE;
                end
                ST_FAIL: begin
                    ce_n     <= 1'b1;
                    copy_err <= 1'b1;
                    if (!boot_mode) req_done <= 1'b1;
                    boot_mode <= 1'b0;
                    state     <= ST_IDLE;
                end
                default: begin
                    if (s_done) state <= ret;
                end
            endcase
        end
    end

    always_comb begin
        s_go  = 1'b0;
        s_req = '{op: OP_CMD, data: NBC_OPC_RESET};
        case (state)
            ST_RST_GO:  s_go = 1'b1;
            ST_RD1_GO: begin
                s_go  = 1'b1;
                s_req = '{op: OP_CMD, data: NBC_OPC_READ};
            end
            ST_ADDR_GO: begin
                s_go  = 1'b1;
                s_req = '{op: OP_ADDR, data: nbc_addr_byte(addr_idx, page)};
            end
            ST_RD2_GO: begin
                s_go  = 1'b1;
                s_req = '{op: OP_CMD, data: NBC_OPC_CONFIRM};
            end
            ST_DATA_GO: begin
                s_go  = 1'b1;
                s_req = '{op: OP_READ, data: 8'h00};
            end
            default: ;
        endcase
    end

    assign w_clr       = (state == ST_RST_GO) || (state == ST_RD1_GO) || (state == ST_RD2_GO);
    assign w_arm       = (state == ST_RST_WAIT) || (state == ST_RD_WAIT);
    assign mem_we      = (state == ST_DATA_PUT);
    assign mem_addr    = dest + MEM_AW'(col);
    assign mem_wdata   = s_rdata;
    assign mem_to_sram = boot_mode;

endmodule

// File: rtl/nand_boot_copier.sv
module nand_boot_copier
    import nbc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 32,
    parameter int MEM_AW     = 32,
    parameter int PAGE_BYTES = 2048,
    parameter int BOOT_BYTES = 4096,
    parameter int T_SETUP    = 1,
    parameter int T_PULSE    = 1,
    parameter int T_HOLD     = 1,
    parameter int MIN_WAIT   = 4,
    parameter int RB_TIMEOUT = 4096
) (
    input  logic              clk,
    input  logic              rst,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_io_out,
    output logic              nand_io_oe,
    input  logic [7:0]        nand_io_in,
    input  logic              nand_rb,
    output logic              mem_we,
    output logic              mem_to_sram,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              req_start,
    input  logic [ADDR_W-1:0] req_flash_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [MEM_AW-1:0] req_dest,
    output logic              req_done,
    output logic              cpu_release,
    output logic              copy_err
);
    logic         s_go, s_done;
    nbc_bus_req_t s_req;
    logic [7:0]   s_rdata;
    logic         w_clr, w_arm, w_ready, w_timeout;

    nbc_seq #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MEM_AW(MEM_AW),
        .PAGE_BYTES(PAGE_BYTES), .BOOT_BYTES(BOOT_BYTES)
    ) seq_i (
        .clk(clk), .rst(rst),
        .req_start(req_start), .req_flash_addr(req_flash_addr),
        .req_len(req_len), .req_dest(req_dest),
        .s_go(s_go), .s_req(s_req), .s_done(s_done), .s_rdata(s_rdata),
        .w_clr(w_clr), .w_arm(w_arm), .w_ready(w_ready), .w_timeout(w_timeout),
        .ce_n(nand_ce_n), .mem_we(mem_we), .mem_to_sram(mem_to_sram),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .req_done(req_done), .cpu_release(cpu_release), .copy_err(copy_err)
    );

    nbc_strobe #(
        .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD)
    ) strobe_i (
        .clk(clk), .rst(rst), .go(s_go), .req(s_req), .io_in(nand_io_in),
        .we_n(nand_we_n), .re_n(nand_re_n), .cle(nand_cle), .ale(nand_ale),
        .io_out(nand_io_out), .io_oe(nand_io_oe), .rdata(s_rdata), .done(s_done)
    );

    nbc_rb_wait #(
        .MIN_WAIT(MIN_WAIT), .TIMEOUT(RB_TIMEOUT)
    ) rbw_i (
        .clk(clk), .rst(rst), .rb_async(nand_rb), .clr(w_clr), .arm(w_arm),
        .ready(w_ready), .timeout(w_timeout)
    );

endmodule

// File: rtl/nbc_checker.sv
module nbc_checker (
    input logic clk,
    input logic rst,
    input logic nand_ce_n,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_we_n,
    input logic nand_re_n,
    input logic nand_io_oe,
    input logic mem_we,
    input logic mem_to_sram,
    input logic req_done,
    input logic cpu_release
);
    // R8: done lasts a single cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        req_done |=> !req_done);

    // R11: strobes only while the device is selected
    a_r11_strobe_ce: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    // R11: never both strobes
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));

    // R11: command and address latches exclusive
    a_r11_cle_ale: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    // R11: bus released while the device drives it
    a_r11_read_no_drive: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |-> !nand_io_oe);

    // R2: release never drops once given
    a_r2_release_sticky: assert property (@(posedge clk) disable iff (rst)
        cpu_release |=> cpu_release);

    // R2: SRAM filled before release
    a_r2_sram_before_release: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_to_sram) |-> !cpu_release);

    // R5: memory writes only while a page is open
    a_r5_write_in_page: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !nand_ce_n);
endmodule

bind nand_boot_copier nbc_checker chk_i (
    .clk(clk), .rst(rst), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_oe(nand_io_oe), .mem_we(mem_we), .mem_to_sram(mem_to_sram),
    .req_done(req_done), .cpu_release(cpu_release)
);

// File: tb/nand_boot_copier_tb_top.sv
module nand_boot_copier_tb_top;
    localparam int TP       = 2;
    localparam int TMO      = 300;
    localparam int RST_BUSY = 12;
    localparam int RD_BUSY  = 25;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_out, nand_io_in;
    logic        nand_rb;
    logic        mem_we, mem_to_sram;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        req_start = 1'b0;
    logic [31:0] req_flash_addr = '0, req_len = '0, req_dest = '0;
    logic        req_done, cpu_release, copy_err;

    always #4 clk = ~clk;

    nand_boot_copier #(.T_PULSE(TP), .RB_TIMEOUT(TMO)) dut_i (
        .clk(clk), .rst(rst),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
        .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb(nand_rb),
        .mem_we(mem_we), .mem_to_sram(mem_to_sram), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .req_start(req_start), .req_flash_addr(req_flash_addr),
        .req_len(req_len), .req_dest(req_dest), .req_done(req_done),
        .cpu_release(cpu_release), .copy_err(copy_err)
    );

    function automatic logic [7:0] pat(input int unsigned row, input int unsigned col);
        return 8'(row * 29) ^ 8'(col) ^ 8'((col >> 8) * 77) ^ 8'(row >> 8);
    endfunction

    // ---------------- flash model ----------------
    int          busy_cnt = 0, we_w = 0, re_w = 0, addr_n = 0;
    int          n_reset = 0, n_pages = 0, proto_err = 0, pulse_err = 0;
    logic [7:0]  abyte [5];
    logic        p_cle, p_ale, fresh = 1'b0, ce_cycled = 1'b0;
    logic [7:0]  p_dat;
    int unsigned m_row = 0, m_col = 0;
    logic        stuck = 1'b0;

    assign nand_io_in = pat(m_row, m_col);
    assign nand_rb    = !stuck && (busy_cnt == 0);

    always @(negedge clk) begin
        if (!rst) begin
            if (busy_cnt > 0) busy_cnt--;
            if (nand_ce_n && fresh) ce_cycled = 1'b1;
            if (!nand_we_n) begin
                we_w++;
                p_cle = nand_cle; p_ale = nand_ale; p_dat = nand_io_out;
                if (nand_ce_n || !nand_io_oe || (nand_cle && nand_ale)) proto_err++;
            end else if (we_w > 0) begin
                if (we_w != TP) pulse_err++;
                we_w = 0;
                if (p_cle) begin
                    if (p_dat == 8'hFF) begin
                        n_reset++; busy_cnt = RST_BUSY; fresh = 1'b1; ce_cycled = 1'b0;
                    end else if (p_dat == 8'h00) begin
                        addr_n = 0;
                    end else if (p_dat == 8'h30) begin
                        if (addr_n != 5 || abyte[0] != 0 || abyte[1] != 0 || !fresh || !ce_cycled)
                            proto_err++;
                        fresh = 1'b0;
                        m_row = {8'h00, abyte[4], abyte[3], abyte[2]};
                        m_col = 0;
                        n_pages++;
                        busy_cnt = RD_BUSY;
                    end else proto_err++;
                end else if (p_ale) begin
                    if (addr_n < 5) abyte[addr_n] = p_dat;
                    addr_n++;
                end
            end
            if (!nand_re_n) begin
                re_w++;
                if (nand_ce_n || busy_cnt > 0 || stuck || nand_io_oe) proto_err++;
            end else if (re_w > 0) begin
                if (re_w != TP) pulse_err++;
                re_w = 0;
                m_col++;
            end
        end
    end

    // ---------------- write / done monitor ----------------
    int          wr_cnt = 0, data_err = 0, rel_err = 0, done_cnt = 0, wr_base = 0;
    int unsigned exp_page = 0, exp_dest = 0;
    logic        exp_sram = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (req_done) done_cnt++;
            if (mem_we) begin
                int unsigned off;
                off = mem_addr - exp_dest;
                if (off != 32'(wr_cnt - wr_base)) data_err++;
                else if (mem_wdata != pat(exp_page + off / 2048, off % 2048)) data_err++;
                if (mem_to_sram != exp_sram) data_err++;
                if (mem_to_sram && cpu_release) rel_err++;
                wr_cnt++;
            end
        end
    end

    // ---------------- checking ----------------
    int n_checks = 0, n_fail = 0;
    int b_derr, b_perr, b_pulse, b_pages, b_reset, b_done;
    bit finished = 1'b0;
    int cyc = 0;

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic snap();
        wr_base = wr_cnt;  b_derr = data_err; b_perr = proto_err; b_pulse = pulse_err;
        b_pages = n_pages; b_reset = n_reset; b_done = done_cnt;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 60000 && done_cnt == b_done; k++) @(negedge clk);
    endtask

    task automatic run_copy(input int unsigned addr, input int unsigned len,
                            input int unsigned dest, input bit inject);
        int pages;
        pages = (len + 2047) / 2048;
        @(negedge clk);
        exp_page = addr >> 11; exp_dest = dest; exp_sram = 1'b0;
        snap();
        req_flash_addr = addr; req_len = len; req_dest = dest; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        if (inject) begin
            repeat (400) @(negedge clk);
            req_flash_addr = 32'h0040_0000; req_len = 8000; req_dest = 32'h7000_0000;
            req_start = 1'b1;
            @(negedge clk);
            req_start = 1'b0;
        end
        wait_done();
        repeat (300) @(negedge clk);
        check(wr_cnt - wr_base == pages * 2048, "R6 byte count", wr_cnt - wr_base, pages * 2048);
        check(n_pages - b_pages == pages, "R6 page count", n_pages - b_pages, pages);
        check(data_err == b_derr, "R5/R7 data and order", data_err - b_derr, 0);
        check(n_reset - b_reset == pages, "R3 resets per page", n_reset - b_reset, pages);
        check(proto_err == b_perr, "R4 command/address protocol", proto_err - b_perr, 0);
        check(pulse_err == b_pulse, "R11 strobe width", pulse_err - b_pulse, 0);
        check(done_cnt - b_done == 1, "R8/R9 done count", done_cnt - b_done, 1);
        check(copy_err == 1'b0, "R10 no error", copy_err, 0);
        check(nand_ce_n == 1'b1, "R5 CE released", nand_ce_n, 1);
    endtask

    initial begin
        wait (cyc >= 195000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (8) @(negedge clk);
        check(nand_ce_n && nand_we_n && nand_re_n, "R11 idle bus in reset", nand_ce_n, 1);
        check(!cpu_release, "R2 release low in reset", cpu_release, 0);
        check(!mem_we && !req_done, "R8 no activity in reset", mem_we | req_done, 0);

        // boot copy with a stray start pulse
        exp_page = 0; exp_dest = 0; exp_sram = 1'b1;
        snap();
        rst = 1'b0;
        repeat (200) @(negedge clk);
        req_flash_addr = 32'h0001_0000; req_len = 4096; req_dest = 32'h5000_0000; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        check(!cpu_release, "R2 release low during boot", cpu_release, 0);
        for (int k = 0; k < 60000 && !cpu_release; k++) @(negedge clk);
        check(wr_cnt == 4096, "R1 boot byte count", wr_cnt, 4096);
        repeat (300) @(negedge clk);
        check(cpu_release, "R2 release after boot", cpu_release, 1);
        check(wr_cnt == 4096, "R9 start ignored during boot", wr_cnt, 4096);
        check(data_err == 0, "R1 boot data", data_err, 0);
        check(rel_err == 0, "R2 no SRAM write after release", rel_err, 0);
        check(n_reset == 2 && n_pages == 2, "R3 boot resets", n_reset, 2);
        check(done_cnt == 0, "R8 no done for boot", done_cnt, 0);
        check(proto_err == 0 && pulse_err == 0, "R4 boot protocol", proto_err + pulse_err, 0);

        // partial page, unaligned start
        run_copy(32'd5 * 2048 + 77, 100, 32'h1000_0000, 1'b0);
        // just over one page, with ignored start mid-copy
        run_copy(32'h0002_0000, 2049, 32'h2000_0000, 1'b1);
        // zero length
        run_copy(32'h0000_8000, 0, 32'h3000_0000, 1'b0);
        // random single-page requests, high row bytes exercised
        for (int r = 0; r < 2; r++) begin
            int unsigned a, l, d;
            a = ($urandom() % 32'h00FF_FFFF) << 11 | ($urandom() % 2048);
            l = 1 + ($urandom() % 2048);
            d = $urandom() & 32'hFFFF_F000;
            run_copy(a, l, d, 1'b0);
        end

        // ready/busy timeout
        @(negedge clk);
        stuck = 1'b1;
        snap();
        req_flash_addr = 32'h0000_4000; req_len = 100; req_dest = 32'h4000_0000; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        wait_done();
        repeat (50) @(negedge clk);
        check(copy_err == 1'b1, "R10 error on timeout", copy_err, 1);
        check(wr_cnt == wr_base, "R10 no writes after timeout", wr_cnt - wr_base, 0);
        check(done_cnt - b_done == 1, "R10 done on timeout", done_cnt - b_done, 1);
        check(nand_ce_n == 1'b1, "R10 CE released", nand_ce_n, 1);
        stuck = 1'b0;
        repeat (10) @(negedge clk);
        run_copy(32'h0000_4000, 2048, 32'h4000_0000, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule